// File: doc/BRIEF.md
# FPGA SPI Configuration Loader

This block brings up an SRAM-based FPGA whose configuration port behaves as an SPI slave. After reset, or when asked to reload, it reads a 32-bit bitstream byte count from the parameter bank of a byte-wide non-volatile store. A count that is too large is refused. Otherwise the block pulses the FPGA reset line, waits for it to settle, and streams the bitstream bytes out of a second bank over an SPI master port. Fixed runs of dummy clocks go before and after the data.

The store is reached through a simple request/response port: a one-cycle `mem_req` with bank and address, answered later by `mem_rvalid` with the data byte. Once the trailing clocks are out, the block watches the FPGA's done pin. It raises `configured` if done goes high within a programmable window, and an error flag if it does not. Key inputs pass to `key_out` only while `configured` is high. A `reload` pulse repeats the whole sequence from the stored count without resetting the block.

Top module: `fpga_cfg_loader`

## Requirements
- R1: The byte count is fetched first, as four reads of bank 0 (`mem_bank`=0) at addresses LEN_ADDR (default 0x00B0) through LEN_ADDR+3, in that order. The first byte is the least significant.
- R2: A count above MAX_LEN (65536) sets `err_len` and starts nothing else. No reset pulse, no SCK edge and no bank 1 read follow, and `configured` stays low.
- R3: Before any SCK edge, `fpga_reset_n` is held low for exactly RST_CYCLES clocks. At least SETTLE_CYCLES clocks then pass before the first SCK edge.
- R4: The first 8 SCK rising edges carry dummy zero bits with `spi_cs_n` high.
- R5: Bitstream bytes are read from bank 1 (`mem_bank`=1) at addresses 0, 1, 2, … up to count−1. Each byte is shifted out MSB first in SPI mode 3, with `spi_cs_n` low. SCK idles high, MOSI changes only while SCK is low, and the slave samples on the rising edge.
- R6: After the last data byte, 48 dummy zero bits are clocked out with `spi_cs_n` still low. Then `spi_cs_n` returns high. A count of zero sends only the leading and trailing dummies.
- R7: `configured` rises only in a cycle after the trailing bits, with chip select released and `fpga_done` sampled high. `done_led` follows `fpga_done` at all times.
- R8: If `fpga_done` stays low for DONE_TIMEOUT clocks after chip select is released, `err_timeout` is set and `configured` stays low.
- R9: `key_out` is all zeros whenever `configured` is low, and equals `key_in` whenever it is high.
- R10: A `reload` pulse given after success or after either error clears the flags and repeats the whole sequence, starting with a fresh count fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; loading starts when it is released |
| reload | input | 1 | Restart the whole load from the store (taken in a finished state) |
| mem_req | output | 1 | One-cycle read request to the store |
| mem_bank | output | 1 | Bank of the request: 0 = parameters, 1 = bitstream |
| mem_addr | output | 16 | Byte address within the bank |
| mem_rdata | input | 8 | Read data byte |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| spi_sck | output | 1 | SPI clock, idle high |
| spi_mosi | output | 1 | SPI data to the FPGA |
| spi_cs_n | output | 1 | SPI chip select, active low |
| fpga_reset_n | output | 1 | FPGA configuration reset, active low |
| fpga_done | input | 1 | FPGA configuration done, active high |
| done_led | output | 1 | Follows `fpga_done` |
| configured | output | 1 | FPGA confirmed configured |
| err_len | output | 1 | Stored count exceeded the limit |
| err_timeout | output | 1 | Done did not arrive in time |
| key_in | input | KEYS | Raw key states |
| key_out | output | KEYS | Key states, masked until configured |

## Verification
On every cycle, the assertions check the following:
- key masking;
- that the flags exclude one another;
- that an oversize count leaves the bus and the reset pin quiet;
- that SCK idles high while the FPGA is in reset;
- the mode 3 stability rules for MOSI and chip select;
- that `configured` rises only after done was sampled high with chip select released.

Only the bench scenarios can show the rest: the exact bit stream and chip select level at each SCK edge, the order of store addresses, the length of the reset pulse, the settle gap, the timeout window, and that a reload repeats the whole load with a new count.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

    typedef enum logic [3:0] {
        ST_LEN_REQ,
        ST_LEN_WAIT,
        ST_CHECK,
        ST_RST,
        ST_SETTLE,
        ST_LEAD,
        ST_DATA_REQ,
        ST_DATA_WAIT,
        ST_DATA_TX,
        ST_TRAIL,
        ST_WAIT_DONE,
        ST_OK,
        ST_ERR_LEN,
        ST_ERR_TO
    } fcl_state_e;

    typedef struct packed {
        logic        req;
        logic        bank;
        logic [15:0] addr;
    } fcl_mem_cmd_t;

    localparam int LEN_BYTES      = 4;
    localparam int LEAD_BITS      = 8;
    localparam int LEAD_BYTES     = LEAD_BITS / 8;
    localparam int TRAIL_BITS_MIN = 47;
    localparam int TRAIL_BYTES    = (TRAIL_BITS_MIN + 7) / 8;
    localparam int DUMMY_CW       = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fcl_spi_byte.sv
module fcl_spi_byte #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] din,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bits;
    logic [7:0]    sh;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            sck  <= 1'b1;
            mosi <= 1'b0;
            busy <= 1'b0;
            cnt  <= '0;
            bits <= '0;
            sh   <= '0;
        end else if (start && !busy) begin
            sh   <= din;
            mosi <= din[7];
            sck  <= 1'b0;
            cnt  <= '0;
            bits <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else if (bits == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    sck  <= 1'b0;
                    bits <= bits + 3'd1;
                    mosi <= sh[6];
                    sh   <= {sh[6:0], 1'b0};
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/fcl_ctrl.sv
module fcl_ctrl
    import fcl_pkg::*;
#(
    parameter int          RST_CYCLES    = 16,
    parameter int          SETTLE_CYCLES = 64,
    parameter int          DONE_TIMEOUT  = 1000,
    parameter int          MAX_LEN       = 65536,
    parameter logic [15:0] LEN_ADDR      = 16'h00B0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    output fcl_mem_cmd_t mem_cmd,
    input  logic [7:0]   mem_rdata,
    input  logic         mem_rvalid,
    output logic         tx_start,
    output logic [7:0]   tx_byte,
    input  logic         tx_done,
    output logic         cs_n,
    output logic         reset_n,
    input  logic         fpga_done,
    output logic         configured,
    output logic         err_len,
    output logic         err_timeout
);
    localparam int CNT_MAX = max3(RST_CYCLES, SETTLE_CYCLES, DONE_TIMEOUT);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int IDX_W   = $clog2(LEN_BYTES);

    fcl_state_e          state;
    logic [IDX_W-1:0]    idx;
    logic [31:0]         len;
    logic [16:0]         addr;
    logic [CNT_W-1:0]    cnt;
    logic [DUMMY_CW-1:0] dcnt;

    always_ff @(posedge clk) begin
        mem_cmd.req <= 1'b0;
        tx_start    <= 1'b0;
        if (rst) begin
            state       <= ST_LEN_REQ;
            idx         <= '0;
            len         <= '0;
            addr        <= '0;
            cnt         <= '0;
            dcnt        <= '0;
            mem_cmd     <= '0;
            tx_byte     <= '0;
            cs_n        <= 1'b1;
            reset_n     <= 1'b1;
            configured  <= 1'b0;
            err_len     <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            unique case (state)
                ST_LEN_REQ: begin
                    mem_cmd.req  <= 1'b1;
                    mem_cmd.bank <= 1'b0;
                    mem_cmd.addr <= LEN_ADDR + 16'(idx);
                    state        <= ST_LEN_WAIT;
                end
                ST_LEN_WAIT: if (mem_rvalid) begin
                    len[8*idx +: 8] <= mem_rdata;
                    if (idx == IDX_W'(LEN_BYTES - 1)) begin
                        state <= ST_CHECK;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_LEN_REQ;
                    end
                end
                ST_CHECK: begin
                    if (len > 32'(MAX_LEN)) begin
                        err_len <= 1'b1;
                        state   <= ST_ERR_LEN;
                    end else begin
                        reset_n <= 1'b0;
                        cnt     <= '0;
                        state   <= ST_RST;
                    end
                end
                ST_RST: begin
                    if (cnt == CNT_W'(RST_CYCLES - 1)) begin
                        reset_n <= 1'b1;
                        cnt     <= '0;
                        state   <= ST_SETTLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_CYCLES - 1)) begin
                        tx_start <= 1'b1;
                        tx_byte  <= 8'h00;
                        dcnt     <= '0;
                        state    <= ST_LEAD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_LEAD: if (tx_done) begin
                    if (dcnt != DUMMY_CW'(LEAD_BYTES - 1)) begin
                        dcnt     <= dcnt + DUMMY_CW'(1);
                        tx_start <= 1'b1;
                    end else begin
                        cs_n <= 1'b0;
                        addr <= '0;
                        dcnt <= '0;
                        if (len == 32'd0) begin
                            tx_start <= 1'b1;
                            tx_byte  <= 8'h00;
                            state    <= ST_TRAIL;
                        end else begin
                            state <= ST_DATA_REQ;
                        end
                    end
                end
                ST_DATA_REQ: begin
                    mem_cmd.req  <= 1'b1;
                    mem_cmd.bank <= 1'b1;
                    mem_cmd.addr <= addr[15:0];
                    state        <= ST_DATA_WAIT;
                end
                ST_DATA_WAIT: if (mem_rvalid) begin
                    tx_start <= 1'b1;
                    tx_byte  <= mem_rdata;
                    addr     <= addr + 17'd1;
                    state    <= ST_DATA_TX;
                end
                ST_DATA_TX: if (tx_done) begin
                    if (32'(addr) == len) begin
                        tx_start <= 1'b1;
                        tx_byte  <= 8'h00;
                        dcnt     <= '0;
                        state    <= ST_TRAIL;
                    end else begin
                        state <= ST_DATA_REQ;
                    end
                end
                ST_TRAIL: if (tx_done) begin
                    if (dcnt == DUMMY_CW'(TRAIL_BYTES - 1)) begin
                        cs_n  <= 1'b1;
                        cnt   <= '0;
                        state <= ST_WAIT_DONE;
                    end else begin
                        dcnt     <= dcnt + DUMMY_CW'(1);
                        tx_start <= 1'b1;
                    end
                end
                ST_WAIT_DONE: begin
                    if (fpga_done) begin
                        configured <= 1'b1;
                        state      <= ST_OK;
                    end else if (cnt == CNT_W'(DONE_TIMEOUT - 1)) begin
                        err_timeout <= 1'b1;
                        state       <= ST_ERR_TO;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_OK, ST_ERR_LEN, ST_ERR_TO: if (reload) begin
                    configured  <= 1'b0;
                    err_len     <= 1'b0;
                    err_timeout <= 1'b0;
                    idx         <= '0;
                    len         <= '0;
                    state       <= ST_LEN_REQ;
                end
                default: state <= ST_LEN_REQ;
            endcase
        end
    end

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import fcl_pkg::*;
#(
    parameter int          CLK_DIV       = 2,
    parameter int          RST_CYCLES    = 16,
    parameter int          SETTLE_CYCLES = 64,
    parameter int          DONE_TIMEOUT  = 1000,
    parameter int          MAX_LEN       = 65536,
    parameter logic [15:0] LEN_ADDR      = 16'h00B0,
    parameter int          KEYS          = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reload,
    output logic            mem_req,
    output logic            mem_bank,
    output logic [15:0]     mem_addr,
    input  logic [7:0]      mem_rdata,
    input  logic            mem_rvalid,
    output logic            spi_sck,
    output logic            spi_mosi,
    output logic            spi_cs_n,
    output logic            fpga_reset_n,
    input  logic            fpga_done,
    output logic            done_led,
    output logic            configured,
    output logic            err_len,
    output logic            err_timeout,
    input  logic [KEYS-1:0] key_in,
    output logic [KEYS-1:0] key_out
);
    fcl_mem_cmd_t mem_cmd;
    logic         tx_start;
    logic [7:0]   tx_byte;
    logic         tx_done;
    logic         tx_busy;

    fcl_ctrl #(
        .RST_CYCLES   (RST_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .DONE_TIMEOUT (DONE_TIMEOUT),
        .MAX_LEN      (MAX_LEN),
        .LEN_ADDR     (LEN_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reload     (reload),
        .mem_cmd    (mem_cmd),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .tx_start   (tx_start),
        .tx_byte    (tx_byte),
        .tx_done    (tx_done),
        .cs_n       (spi_cs_n),
        .reset_n    (fpga_reset_n),
        .fpga_done  (fpga_done),
        .configured (configured),
        .err_len    (err_len),
        .err_timeout(err_timeout)
    );

    fcl_spi_byte #(.DIV(CLK_DIV)) u_spi (
        .clk  (clk),
        .rst  (rst),
        .start(tx_start),
        .din  (tx_byte),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .busy (tx_busy),
        .done (tx_done)
    );

    assign mem_req  = mem_cmd.req;
    assign mem_bank = mem_cmd.bank;
    assign mem_addr = mem_cmd.addr;
    assign done_led = fpga_done;

    for (genvar k = 0; k < KEYS; k++) begin : g_keygate
        assign key_out[k] = key_in[k] & configured;
    end

endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk #(
    parameter int KEYS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            spi_sck,
    input logic            spi_mosi,
    input logic            spi_cs_n,
    input logic            fpga_reset_n,
    input logic            fpga_done,
    input logic            configured,
    input logic            err_len,
    input logic            err_timeout,
    input logic [KEYS-1:0] key_out
);
    a_r9_key_mask: assert property (@(posedge clk) disable iff (rst)
        !configured |-> (key_out == '0));

    a_r2_len_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err_len |-> (spi_sck && spi_cs_n && fpga_reset_n && !mem_req && !configured));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(configured && (err_len || err_timeout)));

    a_r3_sck_idle_in_reset: assert property (@(posedge clk) disable iff (rst)
        !fpga_reset_n |-> spi_sck);

    a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r5_cs_stable_low_sck: assert property (@(posedge clk) disable iff (rst)
        !spi_sck |-> $stable(spi_cs_n));

    a_r7_cfg_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(configured) |-> ($past(fpga_done) && spi_cs_n));

endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk #(.KEYS(KEYS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req     (mem_req),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_cs_n    (spi_cs_n),
    .fpga_reset_n(fpga_reset_n),
    .fpga_done   (fpga_done),
    .configured  (configured),
    .err_len     (err_len),
    .err_timeout (err_timeout),
    .key_out     (key_out)
);

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;
    localparam int DIV     = 2;
    localparam int RSTC    = 4;
    localparam int SETTLE  = 6;
    localparam int TMO     = 40;
    localparam int KEYS    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reload = 1'b0;
    logic        mem_req, mem_bank;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        spi_sck, spi_mosi, spi_cs_n, fpga_reset_n;
    logic        fpga_done = 1'b0;
    logic        done_led, configured, err_len, err_timeout;
    logic [KEYS-1:0] key_in = 8'hA5;
    logic [KEYS-1:0] key_out;

    always #2.5 clk = ~clk;

    fpga_cfg_loader #(
        .CLK_DIV(DIV), .RST_CYCLES(RSTC), .SETTLE_CYCLES(SETTLE),
        .DONE_TIMEOUT(TMO), .MAX_LEN(65536), .LEN_ADDR(16'h00B0), .KEYS(KEYS)
    ) u_dut (
        .clk(clk), .rst(rst), .reload(reload),
        .mem_req(mem_req), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .fpga_reset_n(fpga_reset_n), .fpga_done(fpga_done), .done_led(done_led),
        .configured(configured), .err_len(err_len), .err_timeout(err_timeout),
        .key_in(key_in), .key_out(key_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11);
    endfunction

    // store model
    logic [31:0] mem_len = 32'd3;
    int len_idx = 0, data_idx = 0, mem_wait = -1;
    logic [7:0] mem_hold;

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_wait == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_hold;
            mem_wait   <= -1;
        end else if (mem_wait > 0) begin
            mem_wait <= mem_wait - 1;
        end
        if (mem_req && !rst) begin
            if (!mem_bank) begin
                chk(mem_addr == 16'(16'h00B0 + len_idx), "R1 length address", mem_addr, 16'h00B0 + len_idx);
                mem_hold = (mem_addr >= 16'h00B0 && mem_addr <= 16'h00B3) ?
                           mem_len[8*(mem_addr-16'h00B0) +: 8] : 8'hEE;
                len_idx++;
            end else begin
                chk(mem_addr == 16'(data_idx), "R5 data address", mem_addr, data_idx);
                mem_hold = pat(int'(mem_addr));
                data_idx++;
            end
            mem_wait <= 2;
        end
    end

    // scoreboard of {cs_n, mosi} at each SCK rising edge
    logic [1:0] exp_q[$];
    bit sb_on = 1'b1;
    logic prev_sck = 1'b1, prev_rn = 1'b1, prev_cs = 1'b1;
    int rst_low = 0, rst_pulses = 0, settle_cnt = -1, sck_falls = 0;
    bit done_en = 1'b1;
    int done_dly = -1, wait_cnt = 0, counting = 0;

    task automatic expect_load(input int n);
        for (int i = 0; i < 8; i++) exp_q.push_back(2'b10);
        for (int a = 0; a < n; a++)
            for (int b = 7; b >= 0; b--) exp_q.push_back({1'b0, pat(a)[b]});
        for (int i = 0; i < 48; i++) exp_q.push_back(2'b00);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!prev_sck && spi_sck && sb_on) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected SCK edge", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    chk({spi_cs_n, spi_mosi} == e, "R4/R5/R6 bit and chip select", {spi_cs_n, spi_mosi}, e);
                end
            end
            if (prev_sck && !spi_sck) begin
                sck_falls++;
                if (settle_cnt >= 0) begin
                    chk(settle_cnt >= SETTLE, "R3 settle gap", settle_cnt, SETTLE);
                    settle_cnt = -1;
                end
            end
            if (!fpga_reset_n) begin
                rst_low++;
                chk(spi_sck == 1'b1, "R3 no SCK in reset", spi_sck, 1);
            end
            if (!prev_rn && fpga_reset_n) begin
                chk(rst_low == RSTC, "R3 reset pulse length", rst_low, RSTC);
                rst_pulses++;
                rst_low = 0;
                settle_cnt = 1;
            end else if (settle_cnt >= 0) begin
                settle_cnt++;
            end
            // FPGA done model
            if (!fpga_reset_n) fpga_done <= 1'b0;
            if (!prev_cs && spi_cs_n) begin
                counting = 1;
                wait_cnt = 1;
                if (done_en) done_dly = 5;
            end else if (counting && !err_timeout && !configured) begin
                wait_cnt++;
            end else begin
                counting = 0;
            end
            if (done_dly == 0) begin
                fpga_done <= 1'b1;
                done_dly = -1;
            end else if (done_dly > 0) begin
                done_dly--;
            end
        end
        prev_sck = spi_sck;
        prev_rn  = fpga_reset_n;
        prev_cs  = spi_cs_n;
    end

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (configured || err_len || err_timeout) return;
        end
        chk(1'b0, "watchdog", cyc, limit);
    endtask

    task automatic do_reload(input logic [31:0] n);
        mem_len  = n;
        len_idx  = 0;
        data_idx = 0;
        @(negedge clk);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
    endtask

    initial begin
        int pulses0, falls0;
        // reset state
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1 && spi_sck == 1 && fpga_reset_n == 1, "R3 reset idle pins", {spi_cs_n, spi_sck, fpga_reset_n}, 7);
        chk(configured == 0 && err_len == 0 && err_timeout == 0, "R7 reset flags", {configured, err_len, err_timeout}, 0);
        chk(key_out == '0, "R9 keys masked in reset", key_out, 0);
        expect_load(3);
        rst = 1'b0;
        wait_end(5000);
        chk(configured == 1, "R7 configured after done", configured, 1);
        chk(exp_q.size() == 0, "R6 all bits sent", exp_q.size(), 0);
        chk(len_idx == 4, "R1 four length reads", len_idx, 4);
        chk(key_out == key_in, "R9 keys pass when configured", key_out, key_in);
        chk(done_led == fpga_done, "R7 done_led mirrors done", done_led, fpga_done);
        key_in = 8'h3C;
        @(negedge clk);
        chk(key_out == 8'h3C, "R9 key pattern 2", key_out, 8'h3C);

        // reload with a new count
        expect_load(5);
        do_reload(32'd5);
        @(negedge clk);
        chk(configured == 0 && key_out == '0, "R10 reload clears configured", {configured, key_out}, 0);
        wait_end(5000);
        chk(configured == 1 && data_idx == 5, "R10 reload repeats load", data_idx, 5);
        chk(exp_q.size() == 0, "R5 five bytes sent", exp_q.size(), 0);

        // zero count: dummies only
        expect_load(0);
        do_reload(32'd0);
        wait_end(5000);
        chk(configured == 1 && data_idx == 0, "R6 zero count", data_idx, 0);
        chk(exp_q.size() == 0, "R6 zero count dummies", exp_q.size(), 0);

        // oversize count
        pulses0 = rst_pulses;
        falls0  = sck_falls;
        do_reload(32'd65537);
        wait_end(500);
        chk(err_len == 1 && configured == 0, "R2 oversize flagged", {err_len, configured}, 2);
        repeat (50) @(negedge clk);
        chk(rst_pulses == pulses0 && fpga_reset_n == 1, "R2 no reset pulse", rst_pulses, pulses0);
        chk(sck_falls == falls0, "R2 no SCK", sck_falls, falls0);
        chk(data_idx == 0, "R2 no bitstream reads", data_idx, 0);
        chk(key_out == '0, "R9 masked after error", key_out, 0);

        // done never arrives
        done_en = 1'b0;
        expect_load(2);
        do_reload(32'd2);
        wait_end(5000);
        chk(err_timeout == 1 && configured == 0, "R8 timeout flagged", {err_timeout, configured}, 2);
        chk(wait_cnt == TMO, "R8 timeout window", wait_cnt, TMO);
        chk(done_led == 0, "R7 done_led low", done_led, 0);

        // recover after timeout
        done_en = 1'b1;
        expect_load(1);
        do_reload(32'd1);
        wait_end(5000);
        chk(configured == 1 && err_timeout == 0, "R10 reload after timeout", {configured, err_timeout}, 2);

        // boundary count 65536 is accepted
        sb_on = 1'b0;
        exp_q.delete();
        pulses0 = rst_pulses;
        do_reload(32'd65536);
        for (int i = 0; i < 500 && data_idx < 2; i++) @(negedge clk);
        chk(err_len == 0 && data_idx >= 2, "R2 limit count accepted", data_idx, 2);
        chk(rst_pulses == pulses0 + 1, "R3 reset pulse for limit count", rst_pulses, pulses0 + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog expired", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule